// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block takes one byte from a single-entry holding register and shifts it out on a serial line. Each character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. All timing comes from a one-cycle tick input that pulses at 16 times the bit rate. A host writes a byte, which clears the empty flag. The sequencer takes the byte at a tick while clear-to-send is low, and taking it sets the flag again. The word length, parity and stop settings in force at that tick are latched and used for the whole character. A control code can switch new characters off or hold the line low as a break.

The state machine has six states:
- `ST_IDLE`: the line is high.
- `ST_START`: the line is low for the start bit.
- `ST_DATA`: one data bit goes out per 16 ticks.
- `ST_PARITY`: the parity bit goes out.
- `ST_STOP`: the line is high for 16, 24 or 32 ticks.
- `ST_BREAK`: the line is held low.

The transitions are:
- `ST_IDLE` to `ST_BREAK`: on any clock while break is requested.
- `ST_IDLE` to `ST_START`: on a tick when a start is allowed (the byte is taken).
- `ST_START` to `ST_DATA`: after 16 ticks.
- `ST_DATA` to `ST_PARITY` or `ST_STOP`: after the last data bit.
- `ST_PARITY` to `ST_STOP`: after 16 ticks.
- `ST_STOP` at the end of the stop period: to `ST_BREAK` if break is requested, else to `ST_START` if a start is allowed (back-to-back), else to `ST_IDLE`.
- `ST_BREAK` to `ST_IDLE`: as soon as the break request goes away.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset `txd` is 1 and `tde` is 1.
- R2: A character is a start bit at 0, then the data bits with bit 0 first, then the stop period at 1. Every start, data and parity bit lasts exactly 16 ticks. Within a character, `txd` changes only in the clock after a tick.
- R3: `tde` becomes 1 in the clock in which the held byte is taken, which is the first clock of its start bit.
- R4: A write (`wr_en`=1) makes `tde` 0 in the next clock.
- R5: `wl_sel` sets the number of data bits: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Unused upper bits of the byte are neither sent nor counted in parity.
- R6: With `par_en`=0 no parity bit is sent. With `par_en`=1 one parity bit follows the last data bit:
  - `par_sel` 00: odd parity, so the total count of ones is odd.
  - `par_sel` 01: even parity.
  - `par_sel` 10: the bit is always 1.
  - `par_sel` 11: the bit is always 0.
- R7: With `stop_sel`=0 the stop period is 16 ticks. With `stop_sel`=1 it is:
  - 16 ticks for 8 data bits with parity;
  - 24 ticks for 5 data bits without parity;
  - 32 ticks otherwise.
- R8: A character starts only while `cts_n` is 0. A character already started finishes unchanged if `cts_n` rises.
- R9: `tx_ctl`=11 holds `txd` at 0 from the clock after it is seen in idle, or from the end of the character in progress. When the code changes, `txd` returns to 1 in the next clock.
- R10: `tx_ctl`=00 starts no character. The held byte stays and `tde` stays 0. Codes 01 and 10 both enable normal sending.
- R11: Changing `wl_sel`, `par_en`, `par_sel` or `stop_sel` during a character does not alter that character.
- R12: When a byte is waiting and a start is allowed, its start bit begins in the clock right after the last stop tick, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| wl_sel | input | 2 | Word length code |
| par_en | input | 1 | Parity bit present |
| par_sel | input | 2 | Parity kind |
| stop_sel | input | 1 | Stop length select |
| tx_ctl | input | 2 | 00 off, 01/10 on, 11 break |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line, idle high |
| tde | output | 1 | Holding register empty |

## Verification
The bench builds the block with its defaults, `DATA_W`=8 and `OVERSAMPLE`=16. With `DATA_W`=8 all four word-length codes map to real lengths, and both the 8-bit-with-parity and the 5-bit stop exceptions can be reached. It drives one tick every three clocks, so the clocks between ticks show that bit boundaries move only on ticks. A stop period of 24 ticks appears as exactly 24 high samples. Stop lengths are measured precisely by queueing a second byte and checking that its start bit follows the last stop tick at once.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_BREAK  = 3'd5
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2
    } stop_kind_e;

    localparam logic [1:0] CTL_OFF   = 2'b00;
    localparam logic [1:0] CTL_BREAK = 2'b11;

    localparam logic [1:0] PAR_ODD   = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_MARK  = 2'b10;
    localparam logic [1:0] PAR_SPACE = 2'b11;

    // Per-character settings, latched when a byte is taken.
    typedef struct packed {
        logic [1:0] wl_sel;
        logic       par_on;
        logic       par_bit;
        stop_kind_e stop;
    } frame_cfg_t;

endpackage

// File: rtl/txb_hold.sv
module txb_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_q,
    output logic              empty_q
);

    // A write in the same clock as a take wins: the old byte leaves,
    // the new byte stays, and the register remains full.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr_en) begin
            hold_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (take) begin
            empty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/txb_frame_cfg.sv
module txb_frame_cfg
    import uart_tx_brk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wl_sel,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              stop_sel,
    output frame_cfg_t        cfg
);

    localparam int NB_W = $clog2(DATA_W + 1);
    localparam logic [NB_W-1:0] NB_FULL  = NB_W'(DATA_W);
    localparam logic [NB_W-1:0] NB_SHORT = NB_W'(DATA_W - 3);

    logic [NB_W-1:0]   nbits;
    logic [DATA_W-1:0] used;
    logic              data_xor;

    assign nbits = NB_FULL - NB_W'(wl_sel);

    // Mask off bits above the selected word length.
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_mask
            assign used[g] = (int'(nbits) > g);
        end
    endgenerate

    assign data_xor = ^(data & used);

    always_comb begin
        cfg        = '0;
        cfg.wl_sel = wl_sel;
        cfg.par_on = par_en;
        unique case (par_sel)
            PAR_ODD:   cfg.par_bit = ~data_xor;
            PAR_EVEN:  cfg.par_bit = data_xor;
            PAR_MARK:  cfg.par_bit = 1'b1;
            PAR_SPACE: cfg.par_bit = 1'b0;
            default:   cfg.par_bit = 1'b0;
        endcase
        if (!stop_sel) begin
            cfg.stop = STOP_ONE;
        end else if (par_en && (nbits == NB_FULL)) begin
            cfg.stop = STOP_ONE;
        end else if (!par_en && (nbits == NB_SHORT)) begin
            cfg.stop = STOP_ONE_HALF;
        end else begin
            cfg.stop = STOP_TWO;
        end
    end

endmodule

// File: rtl/txb_seq.sv
module txb_seq
    import uart_tx_brk_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        tx_ctl,
    input  logic              cts_n,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    output logic              take,
    output logic              txd,
    output tx_state_e         state_q
);

    localparam int CNT_W = $clog2(2 * OVERSAMPLE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int NB_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVERSAMPLE - 1);

    tx_state_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    frame_cfg_t        cfg_q;

    logic [CNT_W-1:0]  seg_last;
    logic              seg_end;
    logic [NB_W-1:0]   nbits_q;
    logic              last_bit;
    logic              can_start;
    logic              want_break;

    assign want_break = (tx_ctl == CTL_BREAK);
    assign can_start  = (tx_ctl != CTL_OFF) && !want_break && !hold_empty && !cts_n;
    assign nbits_q    = NB_W'(DATA_W) - NB_W'(cfg_q.wl_sel);
    assign last_bit   = (NB_W'(idx_q) == (nbits_q - NB_W'(1)));

    always_comb begin
        seg_last = BIT_LAST;
        if (state_q == ST_STOP) begin
            unique case (cfg_q.stop)
                STOP_ONE:      seg_last = BIT_LAST;
                STOP_ONE_HALF: seg_last = HALF_LAST;
                STOP_TWO:      seg_last = TWO_LAST;
                default:       seg_last = BIT_LAST;
            endcase
        end
    end

    assign seg_end = tick && (cnt_q == seg_last);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (want_break) begin
                    state_d = ST_BREAK;
                end else if (tick && can_start) begin
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START: begin
                if (seg_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (seg_end && last_bit) begin
                    state_d = cfg_q.par_on ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (seg_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (seg_end) begin
                    if (want_break) begin
                        state_d = ST_BREAK;
                    end else if (can_start) begin
                        state_d = ST_START;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BREAK: begin
                if (!want_break) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and per-character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_d != state_q) || seg_end ||
                (state_q == ST_IDLE) || (state_q == ST_BREAK)) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (take) begin
                idx_q <= '0;
                sh_q  <= hold_data;
                cfg_q <= cfg_in;
            end else if ((state_q == ST_DATA) && seg_end) begin
                idx_q <= idx_q + IDX_W'(1);
                sh_q  <= sh_q >> 1;
            end
        end
    end

    // Line level from state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = sh_q[0];
            ST_PARITY: txd = cfg_q.par_bit;
            ST_STOP:   txd = 1'b1;
            ST_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_brk_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wl_sel,
    input  logic              par_en,
    input  logic [1:0]        par_sel,
    input  logic              stop_sel,
    input  logic [1:0]        tx_ctl,
    input  logic              cts_n,
    output logic              txd,
    output logic              tde
);

    logic [DATA_W-1:0] hold_w;
    logic              take_w;
    frame_cfg_t        cfg_w;
    tx_state_e         seq_state;

    txb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_w),
        .hold_q  (hold_w),
        .empty_q (tde)
    );

    txb_frame_cfg #(.DATA_W(DATA_W)) u_cfg (
        .data     (hold_w),
        .wl_sel   (wl_sel),
        .par_en   (par_en),
        .par_sel  (par_sel),
        .stop_sel (stop_sel),
        .cfg      (cfg_w)
    );

    txb_seq #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .tx_ctl     (tx_ctl),
        .cts_n      (cts_n),
        .hold_empty (tde),
        .hold_data  (hold_w),
        .cfg_in     (cfg_w),
        .take       (take_w),
        .txd        (txd),
        .state_q    (seq_state)
    );

endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk
    import uart_tx_brk_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      wr_en,
    input logic [1:0] tx_ctl,
    input logic      cts_n,
    input logic      txd,
    input logic      tde,
    input logic      take,
    input tx_state_e state
);

    // R4: a write empties nothing; the flag is 0 next clock
    assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tde);

    // R3: taking the byte sets the flag unless a write collides
    assert_take_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> tde);

    // R8: no character begins while clear-to-send is inactive
    assert_take_needs_cts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!cts_n && !tde));

    // R10: the off code never lets a byte be taken
    assert_off_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctl == 2'b00) |-> !take);

    // R2: inside a character the line only moves after a tick
    assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && (state != ST_BREAK) && !tick) |=> $stable(txd));

    // R9: break requested in idle pulls the line low next clock
    assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_ctl == 2'b11) && (state == ST_IDLE)) |=> !txd);

    // R9: leaving break returns the line high next clock
    assert_break_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BREAK) && (tx_ctl != 2'b11)) |=> txd);

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .tx_ctl (tx_ctl),
    .cts_n  (cts_n),
    .txd    (txd),
    .tde    (tde),
    .take   (take_w),
    .state  (seq_state)
);

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wl_sel = 2'b00;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       stop_sel = 1'b0;
    logic [1:0] tx_ctl = 2'b01;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       tde;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  tick_run = 1'b0;
    int  ph = 0;
    logic tde_at_start;

    uart_tx_brk dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .wl_sel(wl_sel), .par_en(par_en), .par_sel(par_sel), .stop_sel(stop_sel),
        .tx_ctl(tx_ctl), .cts_n(cts_n), .txd(txd), .tde(tde)
    );

    always #2 clk = ~clk;

    // One tick every three clocks, changed away from both edges
    initial begin
        forever begin
            @(posedge clk);
            #1;
            ph   = (ph == 2) ? 0 : ph + 1;
            tick = tick_run && (ph == 2);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_par(input logic [7:0] d, input int nb, input logic [1:0] ps);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (ps)
            2'b00:   return (ones % 2) == 0;
            2'b01:   return (ones % 2) == 1;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Waits for a start bit, then compares one sample per tick
    task automatic check_frame(input string tag, input logic [7:0] d, input int nb,
                               input bit pon, input bit pval, input int stp);
        logic exp_q [0:255];
        int n = 0;
        int bad = 0;
        int bad_at = 0;
        int waited = 0;
        int k = 0;
        logic act_b = 1'b0;
        for (int i = 0; i < 16; i++) begin exp_q[n] = 1'b0; n++; end
        for (int b = 0; b < nb; b++)
            for (int i = 0; i < 16; i++) begin exp_q[n] = d[b]; n++; end
        if (pon)
            for (int i = 0; i < 16; i++) begin exp_q[n] = pval; n++; end
        for (int i = 0; i < stp; i++) begin exp_q[n] = 1'b1; n++; end
        @(negedge clk);
        while ((txd !== 1'b0) && (waited < 3000)) begin
            @(negedge clk);
            waited++;
        end
        if (txd !== 1'b0) begin
            check(1'b0, {tag, " start bit seen"}, int'(txd), 0);
            return;
        end
        tde_at_start = tde;
        while (k < n) begin
            @(negedge clk);
            if (tick) begin
                if (txd !== exp_q[k]) begin
                    if (bad == 0) begin bad_at = k; act_b = txd; end
                    bad++;
                end
                k++;
            end
        end
        check(bad == 0, $sformatf("%s frame (first bad sample %0d)", tag, bad_at),
              int'(act_b), int'(exp_q[bad_at]));
    endtask

    // Two bytes back to back; the second start must follow the stop at once
    task automatic pair_check(input string tag, input logic [7:0] d1, input logic [7:0] d2,
                              input logic [1:0] wl, input bit pe, input logic [1:0] ps,
                              input bit ss, input int stp);
        int nb = 8 - int'(wl);
        wl_sel = wl; par_en = pe; par_sel = ps; stop_sel = ss;
        write_byte(d1);
        fork
            check_frame(tag, d1, nb, pe, exp_par(d1, nb, ps), stp);
            begin repeat (30) @(negedge clk); write_byte(d2); end
        join
        @(negedge clk);
        check(txd === 1'b0, {tag, " next start right after stop R12"}, int'(txd), 0);
        check_frame({tag, " second"}, d2, nb, pe, exp_par(d2, nb, ps), stp);
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        check(tde === 1'b1, "R1 tde after reset", int'(tde), 1);
        tick_run = 1'b1;
    endtask

    task automatic t_cts_hold;
        int bad = 0;
        cts_n = 1'b1;
        write_byte(8'h5A);
        check(tde === 1'b0, "R4 tde after write", int'(tde), 0);
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1 || tde !== 1'b0) bad++;
        end
        check(bad == 0, "R8 no start while cts_n high", bad, 0);
        cts_n = 1'b0;
        check_frame("R2 8N1 0x5A", 8'h5A, 8, 1'b0, 1'b0, 16);
        check(tde_at_start === 1'b1, "R3 tde set at start bit", int'(tde_at_start), 1);
    endtask

    task automatic t_word_parity;
        pair_check("R6 7 bits odd",  8'h35, 8'h4B, 2'b01, 1'b1, 2'b00, 1'b0, 16);
        pair_check("R6 8 bits even", 8'hC3, 8'h01, 2'b00, 1'b1, 2'b01, 1'b0, 16);
        pair_check("R6 6 bits mark", 8'hEE, 8'h40, 2'b10, 1'b1, 2'b10, 1'b0, 16);
        pair_check("R5 5 bits odd masked", 8'hF3, 8'hE0, 2'b11, 1'b1, 2'b00, 1'b0, 16);
        pair_check("R6 5 bits space", 8'h1F, 8'h15, 2'b11, 1'b1, 2'b11, 1'b0, 16);
    endtask

    task automatic t_stop_bits;
        pair_check("R7 8P sel1 one stop", 8'h81, 8'h7E, 2'b00, 1'b1, 2'b01, 1'b1, 16);
        pair_check("R7 5N sel1 1.5 stop", 8'h0A, 8'h15, 2'b11, 1'b0, 2'b00, 1'b1, 24);
        pair_check("R7 7N sel1 two stop", 8'h2C, 8'h53, 2'b01, 1'b0, 2'b00, 1'b1, 32);
        pair_check("R7 5P sel1 two stop", 8'h09, 8'h12, 2'b11, 1'b1, 2'b01, 1'b1, 32);
        pair_check("R7 5N sel0 one stop", 8'h11, 8'h0E, 2'b11, 1'b0, 2'b00, 1'b0, 16);
        wl_sel = 2'b00; par_en = 1'b0; par_sel = 2'b00; stop_sel = 1'b0;
    endtask

    task automatic t_cfg_latched;
        write_byte(8'h96);
        fork
            check_frame("R11 config change mid-char", 8'h96, 8, 1'b0, 1'b0, 16);
            begin
                repeat (40) @(negedge clk);
                wl_sel = 2'b11; par_en = 1'b1; par_sel = 2'b10; stop_sel = 1'b1;
            end
        join
        wl_sel = 2'b00; par_en = 1'b0; par_sel = 2'b00; stop_sel = 1'b0;
    endtask

    task automatic t_cts_midchar;
        write_byte(8'h71);
        fork
            check_frame("R8 cts rises mid-char", 8'h71, 8, 1'b0, 1'b0, 16);
            begin repeat (50) @(negedge clk); cts_n = 1'b1; end
        join
        cts_n = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_break_idle;
        int bad = 0;
        tx_ctl = 2'b11;
        @(negedge clk);
        check(txd === 1'b0, "R9 break from idle", int'(txd), 0);
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        check(bad == 0, "R9 break held low", bad, 0);
        tx_ctl = 2'b10;
        @(negedge clk);
        check(txd === 1'b1, "R9 break released", int'(txd), 1);
    endtask

    task automatic t_break_midchar;
        int bad = 0;
        write_byte(8'h0F);
        fork
            check_frame("R9 break waits for char", 8'h0F, 8, 1'b0, 1'b0, 16);
            begin repeat (50) @(negedge clk); tx_ctl = 2'b11; end
        join
        @(negedge clk);
        check(txd === 1'b0, "R9 break after char end", int'(txd), 0);
        repeat (60) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        check(bad == 0, "R9 break low after char", bad, 0);
        tx_ctl = 2'b01;
        @(negedge clk);
        check(txd === 1'b1, "R9 line high after break", int'(txd), 1);
    endtask

    task automatic t_off;
        int bad = 0;
        tx_ctl = 2'b00;
        write_byte(8'h3C);
        repeat (300) begin
            @(negedge clk);
            if (txd !== 1'b1 || tde !== 1'b0) bad++;
        end
        check(bad == 0, "R10 off code sends nothing, byte kept", bad, 0);
        tx_ctl = 2'b01;
        check_frame("R10 kept byte sent once enabled", 8'h3C, 8, 1'b0, 1'b0, 16);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_cts_hold();
        t_word_parity();
        t_stop_bits();
        t_cfg_latched();
        t_cts_midchar();
        t_break_idle();
        t_break_midchar();
        t_off();
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule